// File: doc/BRIEF.md
# Adaptive Write Cancellation Controller

This block sits beside the scheduler of one memory bank whose writes take far longer than its reads. While a write occupies the bank, the controller decides whether a read that has just arrived should abort that write. It only decides. Removing the write from the bank, keeping it queued with its original age, and restarting it from zero progress later are all left to the scheduler. Until the aborted write is redone, the scheduler must serve reads of that line from the write queue, because the stored line is left in an undefined state.

The bar for cancelling depends on how full the write queue is. The allowed-progress percentage starts at 100 for an empty queue and drops by a fixed step for each queued entry. It stops at zero, and at zero nothing is cancelled. A write is aborted only when the share of its service time already spent is strictly below that percentage. The test uses cross-multiplied integers, so no divider is needed. Writes issued in forced mode are never aborted. The block also keeps two counters: one for abort events and one for the service cycles thrown away by those aborts.

Top module: `wcan_ctrl`

## Requirements
- R1: After reset, `cancel_pulse` is 0, `cancel_count` is 0 and `wasted_cycles` is 0.
- R2: The threshold percentage is 100 minus 4 times `wq_count`. A cancel is decided when `wr_elapsed`*100 < threshold*`wr_total`, using a strict comparison. For example, with occupancy 5 and a total of 100, an elapsed value of 79 cancels and an elapsed value of 80 does not.
- R3: A qualifying decision in the cycle where `read_arrive` is high raises `cancel_pulse` in the following cycle. If `read_arrive` is high for one cycle, `cancel_pulse` is high for exactly one cycle.
- R4: When `wr_forced` is 1, `cancel_pulse` never follows, whatever the progress.
- R5: There is no cancel when `read_arrive` is 0, and no cancel when `wr_active` is 0.
- R6: When 4*`wq_count` is 100 or more, the threshold is 0 and no cancel occurs. An occupancy of 24 gives a threshold of 4.
- R7: `cancel_count` increases by 1 in the same cycle `cancel_pulse` rises, holds at other times, and saturates at its all-ones value.
- R8: `wasted_cycles` adds the `wr_elapsed` value of each cancelled write, holds when there is no cancel, and saturates at its all-ones value.
- R9: A write with `wr_total` equal to 0 is never cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| read_arrive | input | 1 | A read request reaches the bank this cycle |
| wr_active | input | 1 | A write is in service at the bank |
| wr_forced | input | 1 | The write in service was issued in forced mode |
| wr_elapsed | input | CYC_W | Service cycles the current write has used so far |
| wr_total | input | CYC_W | Total service cycles of the current write |
| wq_count | input | OCC_W | Current write-queue occupancy |
| cancel_pulse | output | 1 | Abort the current write (one cycle per decision) |
| cancel_count | output | CNT_W | Saturating count of abort events |
| wasted_cycles | output | WASTE_W | Saturating sum of discarded service cycles |

## Verification
The only state in the block is the decision register and the two accumulators, so a fault in any of them shows at the ports no later than the cycle after a read arrives. A wrong threshold or comparison turns a cancel near the boundary into a miss, or a miss into a cancel, on `cancel_pulse` one cycle after the arrival. A counter that steps on the wrong cycle, steps by the wrong amount, or wraps instead of saturating differs from the bench's running totals in that same cycle. The bench keeps those totals independently and compares them after every step.

// File: rtl/wcan_pkg.sv
package wcan_pkg;
   localparam int unsigned PCT_W = 7;
   typedef logic [PCT_W-1:0] pct_t;
endpackage

// File: rtl/wcan_thresh.sv
module wcan_thresh #(
   parameter int unsigned OCC_W    = 6,
   parameter int unsigned STEP     = 4,
   parameter int unsigned FULL_PCT = 100
) (
   input  logic [OCC_W-1:0] occ,
   output wcan_pkg::pct_t   thr
);
   localparam int unsigned EW = OCC_W + 9;

   if (STEP > 255) begin : g_bad_step
      $error("wcan_thresh: STEP must fit in 8 bits");
   end

   logic [EW-1:0] scaled;
   assign scaled = EW'(occ) * EW'(STEP);

   always_comb begin
      if (scaled >= EW'(FULL_PCT)) thr = '0;
      else                         thr = wcan_pkg::PCT_W'(EW'(FULL_PCT) - scaled);
   end
endmodule

// File: rtl/wcan_progress_cmp.sv
module wcan_progress_cmp #(
   parameter int unsigned CYC_W    = 14,
   parameter int unsigned FULL_PCT = 100
) (
   input  logic [CYC_W-1:0] elapsed,
   input  logic [CYC_W-1:0] total,
   input  wcan_pkg::pct_t   thr,
   output logic             below
);
   localparam int unsigned PW = CYC_W + wcan_pkg::PCT_W + 1;

   logic [PW-1:0] done_scaled;
   logic [PW-1:0] limit_scaled;

   assign done_scaled  = PW'(elapsed) * PW'(FULL_PCT);
   assign limit_scaled = PW'(total) * PW'(thr);
   assign below        = done_scaled < limit_scaled;
endmodule

// File: rtl/wcan_acc.sv
module wcan_acc #(
   parameter int unsigned W    = 8,
   parameter int unsigned IN_W = 1,
   parameter bit          SAT  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [IN_W-1:0] inc,
   output logic [W-1:0]    val
);
   if (IN_W > W) begin : g_bad_width
      $error("wcan_acc: increment wider than accumulator");
   end

   if (SAT) begin : g_sat
      logic [W:0] sum;
      assign sum = {1'b0, val} + (W+1)'(inc);
      always_ff @(posedge clk) begin
         if (!rst_n)  val <= '0;
         else if (en) val <= sum[W] ? '1 : sum[W-1:0];
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)  val <= '0;
         else if (en) val <= val + W'(inc);
      end
   end
endmodule

// File: rtl/wcan_ctrl.sv
module wcan_ctrl #(
   parameter int unsigned CYC_W    = 14,
   parameter int unsigned OCC_W    = 6,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned WASTE_W  = 16,
   parameter int unsigned STEP     = 4,
   parameter int unsigned FULL_PCT = 100,
   parameter bit          SAT_CNT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               read_arrive,
   input  logic               wr_active,
   input  logic               wr_forced,
   input  logic [CYC_W-1:0]   wr_elapsed,
   input  logic [CYC_W-1:0]   wr_total,
   input  logic [OCC_W-1:0]   wq_count,
   output logic               cancel_pulse,
   output logic [CNT_W-1:0]   cancel_count,
   output logic [WASTE_W-1:0] wasted_cycles
);
   if (FULL_PCT == 0 || FULL_PCT >= (1 << wcan_pkg::PCT_W)) begin : g_bad_pct
      $error("wcan_ctrl: FULL_PCT out of range");
   end
   if (CYC_W < 1 || OCC_W < 1 || CNT_W < 1) begin : g_bad_w
      $error("wcan_ctrl: widths must be positive");
   end

   wcan_pkg::pct_t thr;
   logic           below;
   logic           eligible;

   wcan_thresh #(.OCC_W(OCC_W), .STEP(STEP), .FULL_PCT(FULL_PCT)) i_thresh (
      .occ (wq_count),
      .thr (thr)
   );

   wcan_progress_cmp #(.CYC_W(CYC_W), .FULL_PCT(FULL_PCT)) i_cmp (
      .elapsed (wr_elapsed),
      .total   (wr_total),
      .thr     (thr),
      .below   (below)
   );

   assign eligible = read_arrive & wr_active & ~wr_forced & below;

   always_ff @(posedge clk) begin
      if (!rst_n) cancel_pulse <= 1'b0;
      else        cancel_pulse <= eligible;
   end

   wcan_acc #(.W(CNT_W), .IN_W(1), .SAT(SAT_CNT)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (eligible),
      .inc   (1'b1),
      .val   (cancel_count)
   );

   wcan_acc #(.W(WASTE_W), .IN_W(CYC_W), .SAT(SAT_CNT)) i_waste (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (eligible),
      .inc   (wr_elapsed),
      .val   (wasted_cycles)
   );
endmodule

// File: rtl/wcan_ctrl_chk.sv
module wcan_ctrl_chk #(
   parameter int unsigned CYC_W    = 14,
   parameter int unsigned OCC_W    = 6,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned WASTE_W  = 16,
   parameter int unsigned STEP     = 4,
   parameter int unsigned FULL_PCT = 100
) (
   input logic               clk,
   input logic               rst_n,
   input logic               read_arrive,
   input logic               wr_active,
   input logic               wr_forced,
   input logic [CYC_W-1:0]   wr_elapsed,
   input logic [CYC_W-1:0]   wr_total,
   input logic [OCC_W-1:0]   wq_count,
   input logic               cancel_pulse,
   input logic [CNT_W-1:0]   cancel_count,
   input logic [WASTE_W-1:0] wasted_cycles
);
   logic queue_full_c;
   assign queue_full_c = (32'(wq_count) * 32'(STEP)) >= 32'(FULL_PCT);

   a_r4_forced_no_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      wr_forced |=> !cancel_pulse);

   a_r5_idle_no_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_active || !read_arrive) |=> !cancel_pulse);

   a_r6_full_no_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      queue_full_c |=> !cancel_pulse);

   a_r9_zero_total: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_total == '0) |=> !cancel_pulse);

   a_r2_partial_only: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_pulse |-> $past(wr_elapsed) < $past(wr_total));

   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_pulse && ($past(cancel_count) != '1)) |->
         cancel_count == CNT_W'($past(cancel_count) + 1'b1));

   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cancel_pulse |-> $stable(cancel_count));

   a_r8_waste_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cancel_pulse |-> $stable(wasted_cycles));
endmodule

bind wcan_ctrl wcan_ctrl_chk #(
   .CYC_W(CYC_W), .OCC_W(OCC_W), .CNT_W(CNT_W), .WASTE_W(WASTE_W),
   .STEP(STEP), .FULL_PCT(FULL_PCT)
) i_wcan_ctrl_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .read_arrive   (read_arrive),
   .wr_active     (wr_active),
   .wr_forced     (wr_forced),
   .wr_elapsed    (wr_elapsed),
   .wr_total      (wr_total),
   .wq_count      (wq_count),
   .cancel_pulse  (cancel_pulse),
   .cancel_count  (cancel_count),
   .wasted_cycles (wasted_cycles)
);

// File: tb/test_wcan_ctrl.sv
module test_wcan_ctrl;
   localparam int unsigned CYC_W   = 14;
   localparam int unsigned OCC_W   = 6;
   localparam int unsigned CNT_W   = 8;
   localparam int unsigned WASTE_W = 16;
   localparam int unsigned CNT_MAX   = (1 << CNT_W) - 1;
   localparam int unsigned WASTE_MAX = (1 << WASTE_W) - 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n = 1'b0;
   logic               read_arrive = 1'b0;
   logic               wr_active = 1'b0;
   logic               wr_forced = 1'b0;
   logic [CYC_W-1:0]   wr_elapsed = '0;
   logic [CYC_W-1:0]   wr_total = '0;
   logic [OCC_W-1:0]   wq_count = '0;
   logic               cancel_pulse;
   logic [CNT_W-1:0]   cancel_count;
   logic [WASTE_W-1:0] wasted_cycles;

   wcan_ctrl i_wcan_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .read_arrive   (read_arrive),
      .wr_active     (wr_active),
      .wr_forced     (wr_forced),
      .wr_elapsed    (wr_elapsed),
      .wr_total      (wr_total),
      .wq_count      (wq_count),
      .cancel_pulse  (cancel_pulse),
      .cancel_count  (cancel_count),
      .wasted_cycles (wasted_cycles)
   );

   int errors = 0;
   int checks = 0;
   int unsigned m_cnt = 0;
   int unsigned m_waste = 0;

   bit          q_c[$];
   int unsigned q_cnt[$];
   int unsigned q_w[$];
   string       q_tag[$];

   task automatic chk(input string tag, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic drive(input string tag, input bit rd, input bit act, input bit frc,
                        input int unsigned el, input int unsigned tot, input int unsigned occ);
      int unsigned thr;
      bit c;
      @(negedge clk);
      read_arrive = rd;
      wr_active   = act;
      wr_forced   = frc;
      wr_elapsed  = CYC_W'(el);
      wr_total    = CYC_W'(tot);
      wq_count    = OCC_W'(occ);
      thr = (occ * 4 >= 100) ? 0 : 100 - 4 * occ;
      c = rd && act && !frc && (longint'(el) * 100 < longint'(thr) * longint'(tot));
      if (c) begin
         if (m_cnt < CNT_MAX) m_cnt++;
         m_waste = (m_waste + el > WASTE_MAX) ? WASTE_MAX : m_waste + el;
      end
      q_c.push_back(c);
      q_cnt.push_back(m_cnt);
      q_w.push_back(m_waste);
      q_tag.push_back(tag);
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && q_c.size() > 0) begin
         bit          ec;
         int unsigned en, ew;
         string       t;
         ec = q_c.pop_front();
         en = q_cnt.pop_front();
         ew = q_w.pop_front();
         t  = q_tag.pop_front();
         chk({t, " cancel"}, longint'(cancel_pulse), longint'(ec));
         chk({t, " count"}, longint'(cancel_count), longint'(en));
         chk({t, " waste"}, longint'(wasted_cycles), longint'(ew));
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset cancel", longint'(cancel_pulse), 0);
      chk("R1 reset count", longint'(cancel_count), 0);
      chk("R1 reset waste", longint'(wasted_cycles), 0);
      rst_n = 1'b1;

      drive("R2 occ5 el79 cancels", 1, 1, 0, 79, 100, 5);
      drive("R3 pulse ends", 0, 1, 0, 79, 100, 5);
      drive("R2 occ5 el80 at bar", 1, 1, 0, 80, 100, 5);
      drive("R2 occ0 el999", 1, 1, 0, 999, 1000, 0);
      drive("R2 occ0 el1000 done", 1, 1, 0, 1000, 1000, 0);
      drive("R2 occ10 el2999", 1, 1, 0, 2999, 5000, 10);
      drive("R2 occ10 el3000", 1, 1, 0, 3000, 5000, 10);
      drive("R6 occ24 el39", 1, 1, 0, 39, 1000, 24);
      drive("R6 occ24 el40", 1, 1, 0, 40, 1000, 24);
      drive("R6 occ25 el0", 1, 1, 0, 0, 1000, 25);
      drive("R6 occ63 el0", 1, 1, 0, 0, 1000, 63);
      drive("R9 total zero", 1, 1, 0, 0, 0, 0);
      drive("R4 forced early", 1, 1, 1, 0, 1000, 0);
      drive("R4 forced mid", 1, 1, 1, 10, 1000, 3);
      drive("R5 no read", 0, 1, 0, 5, 1000, 0);
      drive("R5 no write", 1, 0, 0, 5, 1000, 0);
      drive("R3 back to back a", 1, 1, 0, 7, 1000, 1);
      drive("R3 back to back b", 1, 1, 0, 8, 1000, 1);
      drive("R3 idle after", 0, 0, 0, 0, 0, 0);

      for (int i = 0; i < 20; i++)
         drive("R8 waste saturates", 1, 1, 0, 4000, 16000, 0);
      drive("R8 hold", 0, 1, 0, 4000, 16000, 0);

      for (int i = 0; i < 260; i++)
         drive("R7 count saturates", 1, 1, 0, 1, 100, 2);
      drive("R7 hold", 0, 0, 0, 0, 0, 0);

      repeat (3) @(posedge clk);
      #3;
      chk("R7 queue drained", longint'(q_c.size()), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule